// File: doc/BRIEF.md
# Card Clock Divider with Parking Stop

This block derives the clock sent to a smart card from a faster reference clock. A two-bit rate code selects the reference itself or the reference divided by 2, 4 or 8. A stop request parks the card clock at a chosen level, high or low, and a sequencer enable holds it low while the card is not powered. Alongside the clock the block produces a tick that a cycle counter, such as an answer-to-reset timer, can count. The tick is a reference-cycle-wide pulse for each rising edge of the card clock.

Every transition is planned in units of reference half-periods. On each rising reference edge a small state machine decides the card clock level for the next two half-periods. The first of those halves falls in the low phase of the reference and the second in its high phase. A mux steered by the reference clock then picks the registered level that belongs to the current half. Each of its data inputs is held constant while the mux selects it, so the mux acts as the gating cell and undivided operation can still be parked cleanly. A rate change or a stop only ever acts at the end of a complete phase, so the card never sees a runt pulse.

Top module: `card_clk_div`

## Requirements
- R1: While reset is asserted, `card_clk` and `rise_tick` are both low.
- R2: With `rate_sel` = 2'b00 each high and each low phase of `card_clk` lasts 8 reference half-periods (reference divided by 8).
- R3: With `rate_sel` = 2'b01 each phase lasts 4 reference half-periods (divide by 4).
- R4: With `rate_sel` = 2'b11 each phase lasts 2 reference half-periods (divide by 2).
- R5: With `rate_sel` = 2'b10 each phase lasts one reference half-period, so the card clock runs at the reference rate.
- R6: A new rate is adopted only when a low phase completes, so the first phase at the new rate is a high phase. While a change is in progress, no phase is shorter than the shorter of the two phase lengths involved.
- R7: While `stop_req` is high, the clock completes its current phase and continues normally until it next reaches the level given by `stop_high` (1 = high, 0 = low). Once a full phase at that level has completed, it stays at that level.
- R8: When `stop_req` falls, the parked level ends and the following phase has the full length of the selected rate.
- R9: While `run_en` is low, `card_clk` is held low from the next reference cycle on and `rise_tick` stays low.
- R10: `rise_tick` is high for one reference cycle per card clock rising edge. The pulse is asserted in the reference cycle in which that rising edge is scheduled, so over any stretch that ends with the clock parked the two counts are equal.
- R11: Stop, with either park level, works in undivided mode (`rate_sel` = 2'b10) as it does in divided modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; the card clock is derived from it |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Sequencer enable; low forces the card clock low |
| rate_sel | input | 2 | Rate code: 00 = /8, 01 = /4, 11 = /2, 10 = /1 |
| stop_req | input | 1 | Request to park the card clock |
| stop_high | input | 1 | Park level: 1 = high, 0 = low |
| card_clk | output | 1 | Clock driven to the card |
| rise_tick | output | 1 | One reference cycle pulse for each card clock rising edge |

## Verification
The checker assumes that all control inputs are synchronous to the reference clock, that they change only well away from its rising edge, and that each new value holds for at least one full reference cycle. The parking property also assumes that `stop_high` does not change while a stop is being held. The bench meets these assumptions by changing every input two time units after a falling reference edge. It changes `stop_high` only while no stop is requested and keeps each setting for many cycles. The card clock is sampled one time unit after every reference edge, so each observed level belongs to exactly one half-period.

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [1:0] rate_sel,
  input  logic       stop_req,
  input  logic       stop_high,
  output logic       card_clk,
  output logic       rise_tick
);
  localparam int CNT_W = DIV_W - 1;
  localparam int ST_W  = 1 + CNT_W + DIV_W;

  function automatic logic [DIV_W-1:0] div_of(input logic [1:0] s);
    case (s)
      2'b00:   return DIV_W'(8);
      2'b01:   return DIV_W'(4);
      2'b11:   return DIV_W'(2);
      default: return DIV_W'(1);
    endcase
  endfunction

  // one half-period step: {level, halves left in phase, active divisor}
  function automatic logic [ST_W-1:0] half_step(
    input logic             l,
    input logic [CNT_W-1:0] r,
    input logic [DIV_W-1:0] a,
    input logic             en,
    input logic             stop,
    input logic             sl,
    input logic [DIV_W-1:0] req
  );
    logic [DIV_W-1:0] nd;
    nd = l ? a : req;
    if (!en)                 return {1'b0, CNT_W'(0), req};
    if (r != '0)             return {l, r - CNT_W'(1), a};
    if (stop && (l == sl))   return {l, r, a};
    return {~l, CNT_W'(nd - DIV_W'(1)), nd};
  endfunction

  logic             lvl_q, lo_q, hi_q, tick_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] act_q, want;
  logic [ST_W-1:0]  s1, s2;
  logic             e0, e1;

  assign want = div_of(rate_sel);

  always_comb begin
    s1 = half_step(lvl_q, cnt_q, act_q, run_en, stop_req, stop_high, want);
    s2 = half_step(s1[ST_W-1], s1[DIV_W +: CNT_W], s1[DIV_W-1:0],
                   run_en, stop_req, stop_high, want);
  end

  assign e0 = s1[ST_W-1];
  assign e1 = s2[ST_W-1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      act_q  <= DIV_W'(8);
      lo_q   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      lo_q   <= e0;
      lvl_q  <= e1;
      cnt_q  <= s2[DIV_W +: CNT_W];
      act_q  <= s2[DIV_W-1:0];
      tick_q <= (~lvl_q & e0) | (~e0 & e1);
    end
  end

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) hi_q <= 1'b0;
    else        hi_q <= lvl_q;
  end

  assign card_clk  = ref_clk ? hi_q : lo_q;
  assign rise_tick = tick_q;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic run_en,
  input logic stop_req,
  input logic stop_high,
  input logic card_clk,
  input logic rise_tick,
  input logic lo_half
);
  a_r1_reset_quiet: assert property (@(negedge ref_clk)
    !rst_n |-> (!card_clk && !rise_tick && !lo_half));

  a_r9_no_tick_disabled: assert property (@(negedge ref_clk) disable iff (!rst_n)
    !run_en |-> !rise_tick);

  a_r9_held_low: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (!run_en && $past(!run_en)) |-> !card_clk);

  a_r7_stays_parked: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (run_en && stop_req && (lo_half == stop_high))
      |=> (!run_en || !stop_req || !$stable(stop_high) || (lo_half == stop_high)));

  a_r10_tick_covers_rise: assert property (@(negedge ref_clk) disable iff (!rst_n)
    $rose(lo_half) |-> (rise_tick || $past(rise_tick)));
endmodule

bind card_clk_div card_clk_div_chk chk_i (
  .ref_clk(ref_clk), .rst_n(rst_n), .run_en(run_en), .stop_req(stop_req),
  .stop_high(stop_high), .card_clk(card_clk), .rise_tick(rise_tick), .lo_half(lo_q)
);

// File: tb/card_clk_div_tb.sv
module card_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       stop_req = 1'b0;
  logic       stop_high = 1'b0;
  logic       card_clk, rise_tick;

  int checks = 0, errors = 0;
  int cur_len = 0, last_len = 0, rises = 0, ticks = 0;
  int mon_floor = 0, cur_d = 8;
  logic cur_lvl = 1'b0;
  bit done = 0;
  event phase_done;
  int    exp_len[$];
  string exp_req[$];

  card_clk_div dut_i (.*);

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // half-period sampler
  always @(ref_clk) begin
    #1;
    if (!rst_n) begin
      cur_lvl = 1'b0;
      cur_len = 0;
    end else if (card_clk == cur_lvl) begin
      cur_len++;
    end else begin
      last_len = cur_len;
      cur_lvl  = card_clk;
      cur_len  = 1;
      if (card_clk) rises++;
      ->phase_done;
    end
  end

  always @(posedge ref_clk) begin
    #1;
    if (rst_n && rise_tick) ticks++;
  end

  // scoreboard monitor
  always @(phase_done) begin
    if (mon_floor > 0)
      check(last_len >= mon_floor, "R6 phase floor", last_len, mon_floor);
    if (exp_len.size() > 0) begin
      int e;
      string r;
      e = exp_len.pop_front();
      r = exp_req.pop_front();
      check(last_len == e, r, last_len, e);
    end
  end

  task automatic at_drive;
    @(negedge ref_clk);
    #2;
  endtask

  task automatic expect_rate(input logic [1:0] s, input int d, input string req);
    at_drive();
    mon_floor = (d < cur_d) ? d : cur_d;
    rate_sel = s;
    repeat (3) @(phase_done);
    mon_floor = d;
    cur_d = d;
    @(phase_done);
    #1;
    for (int i = 0; i < 4; i++) begin
      exp_len.push_back(d);
      exp_req.push_back(req);
    end
    while (exp_len.size() != 0) @(posedge ref_clk);
  endtask

  task automatic do_stop(input logic lvl, input string rs, input string rr);
    bit ok;
    at_drive();
    stop_high = lvl;
    stop_req = 1'b1;
    repeat (30) @(posedge ref_clk);
    #3;
    check(card_clk == lvl, rs, card_clk, lvl);
    ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(ref_clk);
      #1;
      if (card_clk !== lvl) ok = 0;
    end
    check(ok, rs, ok, 1);
    check(ticks == rises, "R10", ticks, rises);
    at_drive();
    stop_req = 1'b0;
    @(phase_done);
    @(phase_done);
    check(last_len == cur_d, rr, last_len, cur_d);
  endtask

  initial begin
    repeat (100000) @(posedge ref_clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(posedge ref_clk);
    #3;
    check(card_clk == 1'b0, "R1 clk", card_clk, 0);
    check(rise_tick == 1'b0, "R1 tick", rise_tick, 0);
    at_drive();
    rst_n = 1'b1;
    at_drive();
    run_en = 1'b1;

    expect_rate(2'b00, 8, "R2");
    expect_rate(2'b01, 4, "R3");
    expect_rate(2'b11, 2, "R4");
    expect_rate(2'b10, 1, "R5");
    expect_rate(2'b00, 8, "R6");
    expect_rate(2'b11, 2, "R6");
    expect_rate(2'b00, 8, "R2");

    do_stop(1'b1, "R7 high", "R8 high");
    do_stop(1'b0, "R7 low", "R8 low");
    expect_rate(2'b01, 4, "R3");
    do_stop(1'b1, "R7 high", "R8 high");

    expect_rate(2'b10, 1, "R5");
    do_stop(1'b1, "R11 high", "R11 resume");
    do_stop(1'b0, "R11 low", "R11 resume");

    // enable low holds the clock low
    at_drive();
    mon_floor = 0;
    run_en = 1'b0;
    repeat (2) @(posedge ref_clk);
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(ref_clk);
      #1;
      if (card_clk !== 1'b0 || rise_tick !== 1'b0) ok = 0;
    end
    check(ok, "R9", ok, 1);
    check(ticks == rises, "R10", ticks, rises);
    at_drive();
    run_en = 1'b1;
    expect_rate(2'b11, 2, "R4");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule